// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus, and it serves a 256 x 8 memory held inside the block. An external master drives the serial clock and data lines. The block drives the data line open-drain through an output-enable: asserting the enable pulls the line low, and releasing it lets the line float high. Both lines are brought into the fast system clock through synchronisers. Bus events such as START, STOP and clock edges are decoded from those synchronised samples.

A transaction opens with a device byte. The high nibble of that byte is a fixed type code and the next three bits must equal the select pins. A write transaction then carries a word address, which loads the internal pointer, and any number of data bytes. These data bytes are held in a small staging buffer. They reach the array only when STOP closes the write, during a timed internal write cycle. A read transaction returns bytes starting at the pointer and keeps going for as long as the master acknowledges. A write-protect input silently discards write data.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the data output-enable is deasserted and every array location reads 0x00.
- R2: Until a START is seen (data falling while clock is high), bus activity is ignored and no acknowledge is driven. A START at any point restarts byte reception with a device byte.
- R3: A device byte whose bits 7:4 are 1010 and whose bits 3:1 equal `addr_sel` is acknowledged by pulling data low during the ninth clock. Any other device byte gets no acknowledge, and the slave then ignores the bus until the next START. Bit 0 of the device byte is 1 for read and 0 for write.
- R4: In a write, the word-address byte and every data byte are acknowledged. Successive data bytes go to successive addresses, starting at the word address.
- R5: Write data reaches the array only after a STOP, during the write cycle. A START that arrives before the STOP discards the staged bytes.
- R6: While `wp` is high, data bytes are still acknowledged, but nothing is stored and no write cycle starts.
- R7: A write cycle lasts WRITE_CYCLES system clocks from the STOP. During the cycle, the device byte is not acknowledged.
- R8: A read sends each byte MSB first and sends the next byte whenever the master acknowledges. After a no-acknowledge the data line stays released.
- R9: The pointer advances after every data byte, in both reads and writes, and wraps from 255 to 0.
- R10: Data bytes beyond WBUF_DEPTH in one write are acknowledged and discarded.
- R11: The slave changes its data output only while the clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock from the master |
| sda_i | input | 1 | Resolved level of the data line |
| sda_oe | output | 1 | Data pull-down enable (1 drives the line low) |
| addr_sel | input | 3 | Device select bits compared with device-byte bits 3:1 |
| wp | input | 1 | Write protect, active high, quasi-static |

## Verification
The bench builds the block with WRITE_CYCLES = 400 and WBUF_DEPTH = 4. The short write cycle lets a test address the slave once inside the busy window and again just after it. The four-entry buffer means a six-byte write overflows staging, so the dropped tail can be seen through a read-back. The default 256-byte array is kept, so pointer wrap at 255 is exercised in both directions.

// File: rtl/eeprom_slave_pkg.sv
// Shared types for the serial EEPROM slave.
// Assumes a byte-oriented bus (8 data bits per transfer).
package eeprom_slave_pkg;

    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_RX,     // shifting in a byte from the master
        ST_ACK,    // slave drives or withholds the acknowledge
        ST_TX,     // shifting out a read byte
        ST_RACK    // sampling the master's acknowledge
    } eng_state_t;

    typedef enum logic [1:0] {
        K_DEV,
        K_WORD,
        K_DATA
    } byte_kind_t;

endpackage

// File: rtl/twi_line_sync.sv
// Synchronises the bus clock and data lines into clk and derives edge and
// START/STOP events. Assumes the bus period is many system clocks long.
module twi_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;

    // Shift both lines through the synchroniser chain; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    // Event decode from the current and previous synchronised samples.
    always_comb begin
        scl_s     = scl_pipe[SYNC_STAGES-1];
        sda_s     = sda_pipe[SYNC_STAGES-1];
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        start_det = scl_s & scl_prev & sda_prev & ~sda_s;
        stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
    end

endmodule

// File: rtl/twi_slave_engine.sv
// Protocol engine: receives device, word and data bytes, drives acknowledges,
// shifts out read bytes and owns the address pointer. Assumes event inputs
// come from the line synchroniser and that wp is quasi-static.
module twi_slave_engine
    import eeprom_slave_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [2:0]        addr_sel,
    input  logic              wp,
    input  logic              busy,
    input  logic [BYTE_W-1:0] rdata,
    output logic [ADDR_W-1:0] ptr,
    output logic              push,
    output logic [ADDR_W-1:0] push_addr,
    output logic [BYTE_W-1:0] push_data,
    output logic              clear_stage,
    output logic              commit_req,
    output logic              sda_oe
);

    localparam logic [3:0] BITS_PER_BYTE = 4'(BYTE_W);
    localparam logic [3:0] LAST_TX_BIT   = 4'(BYTE_W - 1);

    eng_state_t        st;
    byte_kind_t        kind;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              rd_mode;
    logic              wr_session;
    logic              master_ack;
    logic              sda_oe_q;
    logic              byte_done;
    logic              dev_match;

    // Byte completion and device-byte decode.
    always_comb begin
        byte_done   = (st == ST_RX) && scl_fall && (bitcnt == BITS_PER_BYTE);
        dev_match   = (shreg[7:4] == DEV_TYPE_CODE) && (shreg[3:1] == addr_sel) && !busy;
        push        = byte_done && (kind == K_DATA) && !wp;
        push_addr   = ptr;
        push_data   = shreg;
        clear_stage = start_det;
        commit_req  = stop_det && wr_session;
        sda_oe      = sda_oe_q;
    end

    // Main protocol sequencer; START and STOP take priority over bit events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            kind       <= K_DEV;
            bitcnt     <= '0;
            shreg      <= '0;
            rd_mode    <= 1'b0;
            wr_session <= 1'b0;
            master_ack <= 1'b0;
            sda_oe_q   <= 1'b0;
            ptr        <= '0;
        end else if (start_det) begin
            st         <= ST_RX;
            kind       <= K_DEV;
            bitcnt     <= '0;
            sda_oe_q   <= 1'b0;
            wr_session <= 1'b0;
        end else if (stop_det) begin
            st         <= ST_IDLE;
            sda_oe_q   <= 1'b0;
            wr_session <= 1'b0;
        end else begin
            case (st)
                ST_RX: begin
                    if (scl_rise && bitcnt != BITS_PER_BYTE) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        case (kind)
                            K_DEV: begin
                                if (dev_match) begin
                                    sda_oe_q   <= 1'b1;
                                    st         <= ST_ACK;
                                    rd_mode    <= shreg[0];
                                    wr_session <= ~shreg[0];
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end
                            K_WORD: begin
                                ptr      <= shreg[ADDR_W-1:0];
                                sda_oe_q <= 1'b1;
                                st       <= ST_ACK;
                            end
                            default: begin
                                ptr      <= ptr + 1'b1;
                                sda_oe_q <= 1'b1;
                                st       <= ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (kind == K_DEV && rd_mode) begin
                            shreg    <= rdata;
                            sda_oe_q <= ~rdata[BYTE_W-1];
                            ptr      <= ptr + 1'b1;
                            st       <= ST_TX;
                        end else begin
                            sda_oe_q <= 1'b0;
                            st       <= ST_RX;
                            kind     <= (kind == K_DEV) ? K_WORD : K_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == LAST_TX_BIT) begin
                            sda_oe_q <= 1'b0;
                            st       <= ST_RACK;
                        end else begin
                            shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe_q <= ~shreg[BYTE_W-2];
                            bitcnt   <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        master_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (master_ack) begin
                            shreg    <= rdata;
                            sda_oe_q <= ~rdata[BYTE_W-1];
                            ptr      <= ptr + 1'b1;
                            bitcnt   <= '0;
                            st       <= ST_TX;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R2: a START always restarts reception with a fresh device byte.
    assert_start_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == ST_RX && kind == K_DEV && bitcnt == 4'd0));

    // R7: no device acknowledge while a write cycle is running.
    assert_nack_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACK && kind == K_DEV && busy) |-> !sda_oe_q);

    // R9: pointer either steps by one (wrapping) or is loaded from a word byte.
    assert_ptr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |->
            (ptr == ADDR_W'($past(ptr) + 1'b1) || $past(byte_done && kind == K_WORD)));

    // R11: the output enable only moves while the synchronised clock is low.
    assert_oe_on_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_q != $past(sda_oe_q)) |-> !$past(scl_s));

endmodule

// File: rtl/write_commit_buffer.sv
// Holds write bytes until STOP, then runs the timed write cycle and drains
// the held bytes into the array one per clock. Assumes WRITE_CYCLES >= DEPTH.
module write_commit_buffer #(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter int DEPTH        = 16,
    parameter int WRITE_CYCLES = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              clear,
    input  logic              commit_req,
    output logic              busy,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata
);

    localparam int IDX_W  = $clog2(DEPTH + 1);
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int TMR_W  = $clog2(WRITE_CYCLES + 1);
    localparam logic [IDX_W-1:0] FULL     = IDX_W'(DEPTH);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WRITE_CYCLES - 1);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [IDX_W-1:0]  idx;
    logic [TMR_W-1:0]  timer;

    // Drain port toward the array while the write cycle runs.
    always_comb begin
        mem_we    = busy && (idx < count);
        mem_waddr = addr_q[idx[SLOT_W-1:0]];
        mem_wdata = data_q[idx[SLOT_W-1:0]];
    end

    // Staging, commit start, drain and write-cycle timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            count <= '0;
            idx   <= '0;
            timer <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                addr_q[i] <= '0;
                data_q[i] <= '0;
            end
        end else if (busy) begin
            if (idx < count) begin
                idx <= idx + 1'b1;
            end
            if (timer == TMR_LAST) begin
                busy  <= 1'b0;
                count <= '0;
                idx   <= '0;
            end else begin
                timer <= timer + 1'b1;
            end
        end else if (commit_req) begin
            if (count != '0) begin
                busy  <= 1'b1;
                timer <= '0;
                idx   <= '0;
            end
        end else if (clear) begin
            count <= '0;
        end else if (push && count < FULL) begin
            addr_q[count[SLOT_W-1:0]] <= push_addr;
            data_q[count[SLOT_W-1:0]] <= push_data;
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/eeprom_cell_array.sv
// Register-file memory: one synchronous write port, one asynchronous read
// port. All cells clear on reset.
module eeprom_cell_array #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    // Write port with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Read port follows the pointer directly.
    always_comb rdata = cells[raddr];

endmodule

// File: rtl/serial_eeprom_slave.sv
// Top level of the two-wire EEPROM slave: line synchroniser, protocol
// engine, write staging with timed commit, and the memory array.
// Assumes scl_i/sda_i are asynchronous and wp/addr_sel are quasi-static.
module serial_eeprom_slave
    import eeprom_slave_pkg::*;
#(
    parameter int MEM_DEPTH    = 256,
    parameter int WBUF_DEPTH   = 16,
    parameter int WRITE_CYCLES = 5000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] addr_sel,
    input  logic       wp
);

    localparam int ADDR_W = $clog2(MEM_DEPTH);
    localparam int CNT_W  = $clog2(WBUF_DEPTH + 1);

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              busy, push, clear_stage, commit_req, mem_we;
    logic [ADDR_W-1:0] ptr, push_addr, mem_waddr;
    logic [BYTE_W-1:0] push_data, mem_wdata, rdata;
    logic [CNT_W-1:0]  stg_count;

    twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twi_slave_engine #(.ADDR_W(ADDR_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .addr_sel(addr_sel), .wp(wp), .busy(busy), .rdata(rdata),
        .ptr(ptr), .push(push), .push_addr(push_addr), .push_data(push_data),
        .clear_stage(clear_stage), .commit_req(commit_req), .sda_oe(sda_oe)
    );

    write_commit_buffer #(
        .ADDR_W(ADDR_W), .DATA_W(BYTE_W),
        .DEPTH(WBUF_DEPTH), .WRITE_CYCLES(WRITE_CYCLES)
    ) u_stage (
        .clk(clk), .rst_n(rst_n), .push(push), .push_addr(push_addr),
        .push_data(push_data), .clear(clear_stage), .commit_req(commit_req),
        .busy(busy), .count(stg_count), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    eeprom_cell_array #(.DEPTH(MEM_DEPTH), .DATA_W(BYTE_W), .ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
        .wdata(mem_wdata), .raddr(ptr), .rdata(rdata)
    );

    // R5: a write cycle only begins on the clock after a detected STOP.
    assert_commit_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    // R6: the staging count grows only when write protect was low.
    assert_wp_blocks_stage_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_count > $past(stg_count)) |-> !$past(wp));

endmodule

// File: tb/tb_serial_eeprom_slave.sv
// Directed bench: a bit-banged bus master, one task per scenario.
module tb_serial_eeprom_slave;

    localparam int WCYC = 400;
    localparam int WBUF = 4;
    localparam int HALF = 10;
    localparam logic [2:0] SEL = 3'b101;
    localparam logic [7:0] DEV_W = 8'hAA;
    localparam logic [7:0] DEV_R = 8'hAB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    int oe_viol = 0;
    logic oe_prev = 1'b0;
    logic oe_after_nack;
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];

    always #10 clk = ~clk;
    assign sda_bus = m_sda & ~sda_oe;

    serial_eeprom_slave #(
        .MEM_DEPTH(256), .WBUF_DEPTH(WBUF), .WRITE_CYCLES(WCYC), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .addr_sel(SEL), .wp(wp)
    );

    // R11 monitor: slave output must not move while the bus clock is high.
    always @(negedge clk) begin
        if (rst_n && sda_oe != oe_prev && m_scl) oe_viol++;
        oe_prev <= sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(6);
        m_scl = 1'b1; tick(HALF);
        m_sda = 1'b0; tick(HALF);
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(6); m_sda = 1'b0; tick(4);
        m_scl = 1'b1; tick(HALF);
        m_sda = 1'b1; tick(HALF);
    endtask

    task automatic put_bit(input logic b);
        tick(6); m_sda = b; tick(4);
        m_scl = 1'b1; tick(HALF);
        m_scl = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        tick(6); m_sda = 1'b1; tick(4);
        m_scl = 1'b1; tick(5);
        b = sda_bus; tick(5);
        m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~give_ack);
    endtask

    // Write n bytes from wbuf at address a, then STOP; returns AND of acks.
    task automatic write_seq(input logic [7:0] a, input int n, output logic all_ack);
        logic ack;
        all_ack = 1'b1;
        bus_start();
        send_byte(DEV_W, ack); all_ack &= ack;
        send_byte(a, ack);     all_ack &= ack;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack); all_ack &= ack;
        end
        bus_stop();
    endtask

    // Random read of n bytes into rbuf; last byte is not acknowledged.
    task automatic read_seq(input logic [7:0] a, input int n, output logic all_ack);
        logic ack;
        logic [7:0] v;
        all_ack = 1'b1;
        bus_start();
        send_byte(DEV_W, ack); all_ack &= ack;
        send_byte(a, ack);     all_ack &= ack;
        bus_start();
        send_byte(DEV_R, ack); all_ack &= ack;
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, v);
            rbuf[i] = v;
        end
        tick(6);
        oe_after_nack = sda_oe;
        bus_stop();
    endtask

    task automatic t_reset();
        logic ok;
        chk("R1 oe after reset", sda_oe, 1'b0);
        read_seq(8'h00, 2, ok);
        chk("R1 read acks", ok, 1'b1);
        chk("R1 cell 0x00", rbuf[0], 8'h00);
        chk("R1 cell 0x01", rbuf[1], 8'h00);
    endtask

    task automatic t_no_start();
        logic ack;
        m_scl = 1'b0;
        send_byte(DEV_W, ack);
        chk("R2 no ack without START", ack, 1'b0);
        bus_stop();
    endtask

    task automatic t_addr();
        logic ack;
        bus_start(); send_byte(DEV_W, ack); bus_stop();
        chk("R3 matching device ack", ack, 1'b1);
        bus_start(); send_byte(8'hA8, ack);
        chk("R3 select mismatch nack", ack, 1'b0);
        bus_stop();
        bus_start(); send_byte(8'h2A, ack);
        chk("R3 type mismatch nack", ack, 1'b0);
        send_byte(8'h00, ack);
        chk("R3 ignored until START", ack, 1'b0);
        bus_stop();
    endtask

    task automatic t_write();
        logic ok;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        write_seq(8'h10, 3, ok);
        chk("R4 write acks", ok, 1'b1);
        tick(WCYC + 100);
        read_seq(8'h10, 3, ok);
        chk("R8 read acks", ok, 1'b1);
        for (int i = 0; i < 3; i++) chk("R4 stored byte", rbuf[i], 8'h11 * (i + 1));
        chk("R8 released after nack", oe_after_nack, 1'b0);
    endtask

    task automatic t_discard();
        logic ack, ok;
        logic [7:0] v;
        ok = 1'b1;
        bus_start();
        send_byte(DEV_W, ack); ok &= ack;
        send_byte(8'h40, ack); ok &= ack;
        send_byte(8'h55, ack); ok &= ack;
        bus_start();
        send_byte(DEV_W, ack); ok &= ack;
        send_byte(8'h40, ack); ok &= ack;
        bus_start();
        send_byte(DEV_R, ack); ok &= ack;
        recv_byte(1'b0, v);
        bus_stop();
        chk("R5 acks around repeated START", ok, 1'b1);
        chk("R5 staged byte discarded", v, 8'h00);
    endtask

    task automatic t_wp();
        logic ok, ack;
        wp = 1'b1;
        wbuf[0] = 8'h77;
        write_seq(8'h50, 1, ok);
        chk("R6 data acked under wp", ok, 1'b1);
        bus_start(); send_byte(DEV_W, ack); bus_stop();
        chk("R6 no write cycle started", ack, 1'b1);
        wp = 1'b0;
        read_seq(8'h50, 1, ok);
        chk("R6 nothing stored", rbuf[0], 8'h00);
    endtask

    task automatic t_busy();
        logic ok, ack;
        wbuf[0] = 8'h12;
        write_seq(8'h60, 1, ok);
        bus_start(); send_byte(DEV_W, ack); bus_stop();
        chk("R7 nack during write cycle", ack, 1'b0);
        tick(WCYC + 100);
        read_seq(8'h60, 1, ok);
        chk("R7 ack after write cycle", ok, 1'b1);
        chk("R7 committed byte", rbuf[0], 8'h12);
    endtask

    task automatic t_wrap();
        logic ok;
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2;
        write_seq(8'hFF, 2, ok);
        tick(WCYC + 100);
        read_seq(8'h00, 1, ok);
        chk("R9 write wrapped to 0x00", rbuf[0], 8'hA2);
        read_seq(8'hFF, 2, ok);
        chk("R9 read at 0xFF", rbuf[0], 8'hA1);
        chk("R9 read wrapped to 0x00", rbuf[1], 8'hA2);
    endtask

    task automatic t_overflow();
        logic ok;
        for (int i = 0; i < 6; i++) wbuf[i] = 8'(i + 1);
        write_seq(8'h20, 6, ok);
        chk("R10 all bytes acked", ok, 1'b1);
        tick(WCYC + 100);
        read_seq(8'h20, 6, ok);
        for (int i = 0; i < 6; i++)
            chk("R10 buffered or dropped", rbuf[i], (i < WBUF) ? 8'(i + 1) : 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_no_start();
        t_addr();
        t_write();
        t_discard();
        t_wp();
        t_busy();
        t_wrap();
        t_overflow();
        chk("R11 output moved only with clock low", oe_viol, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule